// File: doc/BRIEF.md
# Adaptive Resequencing Age Threshold Tracker

This block sets the age threshold for a loose, time-based cell resequencer placed at a switch fabric output. Each cell that leaves the fabric reports its measured network delay. Time is cut into measurement windows of a fixed number of ticks. The block keeps the largest delay seen in the window that is open now and in each of the most recent completed windows, `NUM_WIN` windows in total. It outputs, from a register, a fixed slack plus the largest of those peaks.

The threshold follows the observed network delay. It rises within a cycle of a large delay being seen. It falls back once that peak has aged out of the window history. Using more, shorter windows makes the threshold come down sooner after congestion clears, and ordering stays safe as long as `(NUM_WIN-1)*WINDOW_TICKS >= SLACK`. All values are clamped to the span of the timing wheel, `MAX_SPAN`.

Top module: `age_threshold_tracker`

## Requirements
- R1: While `rst_ni` is low and on the first cycle after its release, `threshold_o` equals `SLACK`, and every window peak is zero.
- R2: The open window's peak is the largest clamped `delay_i` accepted with `delay_valid_i` high since that window opened. A `delay_i` presented with `delay_valid_i` low has no effect on any later `threshold_o`.
- R3: A window closes on every `WINDOW_TICKS`-th clock edge after reset release, counting that release edge as the first. The edge numbered `n*WINDOW_TICKS` ends window `n`.
- R4: On each clock edge, `threshold_o` is loaded with `SLACK` plus the maximum of the open-window peak and the `NUM_WIN-1` completed-window peaks, all taken as they were before that edge.
- R5: When a window closes, its peak enters the history, the oldest completed peak is discarded, and the open peak restarts at zero. A peak therefore affects the threshold for exactly `NUM_WIN` windows.
- R6: A `delay_i` above `MAX_SPAN` is treated as `MAX_SPAN`.
- R7: `threshold_o` never exceeds `MAX_SPAN`. When the sum is larger, `MAX_SPAN` is output.
- R8: A sample accepted on the edge that closes a window counts toward the window being closed, not toward the new one.
- R9: The parameter set must meet `(NUM_WIN-1)*WINDOW_TICKS >= SLACK`, `NUM_WIN >= 2`, `SLACK <= MAX_SPAN` and `MAX_SPAN < 2**DELAY_W`. This is checked at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one tick per edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| delay_valid_i | input | 1 | A delay sample is present this cycle |
| delay_i | input | DELAY_W | Network delay of a departing cell, in ticks |
| threshold_o | output | DELAY_W | Registered age threshold |

## Verification
On every cycle, the assertions check the following:
- `threshold_o` stays between the clamped slack and `MAX_SPAN`.
- The open peak never decreases between window closes.
- All peaks stay within `MAX_SPAN`.
- The window counter wraps right after each close.
- Each new threshold covers the open peak of the cycle before.

Only the bench's cycle-exact reference model can show the rest:
- The threshold falls at the right moment after a spike ages out.
- Samples on a closing edge land in the old window.
- Invalid samples are ignored.
- Saturation gives the exact clamped values.

// File: rtl/age_thr_pkg.sv
package age_thr_pkg;
  function automatic int unsigned clamp_u(input int unsigned v, input int unsigned cap);
    return (v > cap) ? cap : v;
  endfunction
endpackage

// File: rtl/window_timer.sv
module window_timer #(
  parameter int unsigned TICKS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic win_end_o
);
  localparam int unsigned CW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt_q;

  assign win_end_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (win_end_o) cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end

  // R3
  timer_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_end_o |=> (cnt_q == '0));
endmodule

// File: rtl/peak_history.sv
module peak_history #(
  parameter int unsigned DELAY_W  = 10,
  parameter int unsigned NUM_WIN  = 3,
  parameter int unsigned MAX_SPAN = 1000
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            win_end_i,
  input  logic                            valid_i,
  input  logic [DELAY_W-1:0]              delay_i,
  output logic [NUM_WIN-1:0][DELAY_W-1:0] peaks_o
);
  localparam logic [DELAY_W-1:0] CAP = DELAY_W'(MAX_SPAN);

  logic [DELAY_W-1:0] clipped;
  logic [DELAY_W-1:0] open_q;
  logic [DELAY_W-1:0] open_upd;
  logic [NUM_WIN-1:0][DELAY_W-1:0] hist_q;

  assign clipped  = (delay_i > CAP) ? CAP : delay_i;
  assign open_upd = (valid_i && (clipped > open_q)) ? clipped : open_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        open_q <= '0;
    else if (win_end_i) open_q <= '0;
    else                open_q <= open_upd;
  end

  assign hist_q[0]  = open_q;
  assign peaks_o[0] = open_q;

  for (genvar i = 1; i < NUM_WIN; i++) begin : g_hist
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        hist_q[i] <= '0;
      else if (win_end_i) hist_q[i] <= (i == 1) ? open_upd : hist_q[i-1];
    end
    assign peaks_o[i] = hist_q[i];

    // R6
    hist_span_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hist_q[i] <= CAP);
  end

  // R2
  peak_monotonic_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_end_i |=> (open_q >= $past(open_q)));

  // R6
  open_span_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open_q <= CAP);
endmodule

// File: rtl/threshold_reduce.sv
module threshold_reduce
  import age_thr_pkg::*;
#(
  parameter int unsigned DELAY_W  = 10,
  parameter int unsigned NUM_WIN  = 3,
  parameter int unsigned SLACK    = 24,
  parameter int unsigned MAX_SPAN = 1000
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [NUM_WIN-1:0][DELAY_W-1:0] peaks_i,
  output logic [DELAY_W-1:0]              threshold_o
);
  localparam int unsigned SW = DELAY_W + 1;
  localparam logic [SW-1:0] SLACK_V = SW'(SLACK);
  localparam logic [SW-1:0] CAP_W   = SW'(MAX_SPAN);
  localparam logic [DELAY_W-1:0] THR_RST = DELAY_W'(clamp_u(SLACK, MAX_SPAN));

  logic [NUM_WIN-1:0][DELAY_W-1:0] run;
  logic [SW-1:0]      sum;
  logic [DELAY_W-1:0] thr_d;
  logic [DELAY_W-1:0] thr_q;

  assign run[0] = peaks_i[0];
  for (genvar i = 1; i < NUM_WIN; i++) begin : g_max
    assign run[i] = (peaks_i[i] > run[i-1]) ? peaks_i[i] : run[i-1];
  end

  assign sum   = {1'b0, run[NUM_WIN-1]} + SLACK_V;
  assign thr_d = (sum > CAP_W) ? CAP_W[DELAY_W-1:0] : sum[DELAY_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) thr_q <= THR_RST;
    else         thr_q <= thr_d;
  end

  assign threshold_o = thr_q;

  // R7
  thr_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_q <= CAP_W[DELAY_W-1:0]);

  // R4
  thr_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_q >= THR_RST);
endmodule

// File: rtl/age_threshold_tracker.sv
module age_threshold_tracker #(
  parameter int unsigned DELAY_W      = 10,
  parameter int unsigned MAX_SPAN     = 1000,
  parameter int unsigned WINDOW_TICKS = 16,
  parameter int unsigned SLACK        = 24,
  parameter int unsigned NUM_WIN      = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               delay_valid_i,
  input  logic [DELAY_W-1:0] delay_i,
  output logic [DELAY_W-1:0] threshold_o
);
  localparam int unsigned SW = DELAY_W + 1;

  logic win_end;
  logic [NUM_WIN-1:0][DELAY_W-1:0] peaks;

  // R9
  initial begin
    params_ok_chk: assert ((NUM_WIN >= 2) && ((NUM_WIN - 1) * WINDOW_TICKS >= SLACK)
                           && (SLACK <= MAX_SPAN) && (MAX_SPAN < (1 << DELAY_W)))
      else $error("age_threshold_tracker: parameter set breaks ordering or width bound");
  end

  window_timer #(.TICKS(WINDOW_TICKS)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .win_end_o (win_end)
  );

  peak_history #(.DELAY_W(DELAY_W), .NUM_WIN(NUM_WIN), .MAX_SPAN(MAX_SPAN)) u_hist (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .win_end_i (win_end),
    .valid_i   (delay_valid_i),
    .delay_i   (delay_i),
    .peaks_o   (peaks)
  );

  threshold_reduce #(.DELAY_W(DELAY_W), .NUM_WIN(NUM_WIN), .SLACK(SLACK),
                     .MAX_SPAN(MAX_SPAN)) u_thr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .peaks_i     (peaks),
    .threshold_o (threshold_o)
  );

  // R4 R7
  thr_covers_peak_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ({1'b0, threshold_o} >=
              ((({1'b0, $past(peaks[0])} + SW'(SLACK)) > SW'(MAX_SPAN)) ? SW'(MAX_SPAN)
               : ({1'b0, $past(peaks[0])} + SW'(SLACK)))));
endmodule

// File: tb/age_threshold_tracker_tb.sv
module age_threshold_tracker_tb;
  localparam int DW = 10, MAXS = 1000, WT = 16, SL = 24, NW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vld = 1'b0;
  logic [DW-1:0] dly = '0;
  logic [DW-1:0] thr;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  age_threshold_tracker #(.DELAY_W(DW), .MAX_SPAN(MAXS), .WINDOW_TICKS(WT),
                          .SLACK(SL), .NUM_WIN(NW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .delay_valid_i(vld), .delay_i(dly), .threshold_o(thr));

  // behavioural reference
  int m_cnt, m_open, m_thr;
  int m_hist[$];

  function automatic int cap(int v);
    return (v > MAXS) ? MAXS : v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_open = 0; m_thr = cap(SL);
      m_hist = {};
      for (int i = 0; i < NW - 1; i++) m_hist.push_back(0);
    end else begin
      int mx, upd;
      mx = m_open;
      foreach (m_hist[i]) if (m_hist[i] > mx) mx = m_hist[i];
      upd = m_open;
      if (vld && cap(int'(dly)) > upd) upd = cap(int'(dly));
      if (m_cnt == WT - 1) begin
        m_hist.push_front(upd);
        void'(m_hist.pop_back());
        m_open = 0; m_cnt = 0;
      end else begin
        m_open = upd; m_cnt++;
      end
      m_thr = cap(mx + SL);
    end
  end

  task automatic check(string tag);
    n_checks++;
    if (int'(thr) != m_thr) begin
      n_fail++;
      $display("FAIL %s threshold actual=%0d expected=%0d t=%0t", tag, thr, m_thr, $time);
    end
  endtask

  // one cycle: check at negedge, then drive the next inputs
  task automatic step(string tag, bit v, int d);
    @(negedge clk);
    check(tag);
    vld = v; dly = DW'(d);
  endtask

  initial begin
    #1600000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int lf;
    repeat (3) @(negedge clk);
    check("R1 in reset");
    rst_n = 1'b1;
    step("R1 after release", 1'b0, 0);

    // R2: invalid data ignored
    for (int i = 0; i < 40; i++) step("R2 invalid ignored", 1'b0, 500 + i);

    // R3 R5: single spike then decay over windows
    step("R3 R5 spike", 1'b1, 200);
    for (int i = 0; i < 5 * WT; i++) step("R3 R5 decay", 1'b0, 0);

    // R8: sample on the closing edge
    while (m_cnt != WT - 2) step("R8 align", 1'b0, 0);
    step("R8 closing edge", 1'b1, 300);
    step("R8 new window", 1'b1, 50);
    for (int i = 0; i < 4 * WT; i++) step("R8 decay", 1'b0, 0);

    // R2 R4: pseudo-random stream
    lf = 32'h1d3;
    for (int i = 0; i < 400; i++) begin
      lf = (lf * 1103515245 + 12345) & 32'h7fffffff;
      step("R2 R4 stream", lf[3], (lf >> 8) % 600);
    end
    for (int i = 0; i < 4 * WT; i++) step("R4 quiet", 1'b0, 0);

    // R6: over-span samples clamp
    step("R6 oversize", 1'b1, 1023);
    for (int i = 0; i < 4 * WT; i++) step("R6 R7 hold", 1'b0, 0);

    // R7: near-span sum clamps
    step("R7 near span", 1'b1, 990);
    for (int i = 0; i < 2 * WT; i++) step("R7 cap", 1'b0, 0);

    // R1: reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); check("R1 re-reset");
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step("R1 post re-reset", 1'b0, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule